// File: doc/BRIEF.md
# Five-channel down-counting timer

This block is a memory-mapped timer peripheral with five independent channels that count down, attached to a simple 32-bit register bus. Software programs a count buffer for each channel and copies it into the counter with a manual-update bit. It then starts the channel. The channel decrements once per tick. When it reaches zero it raises a status bit and, if that channel's interrupt is enabled, its interrupt line. It then either reloads from its buffer and keeps running, or stops.

Each channel's tick rate comes from two stages. The first is one of two shared 8-bit prescalers: channels 0 and 1 share one, and channels 2 to 4 share the other. The second is a per-channel power-of-two divider. Both stages are one-cycle enables in the single system clock domain. The counter width is a parameter, 16 or 32 bits. Channels 0 to 3 also hold a compare buffer that software can read back. Channel 4 has no compare buffer: its counter observation register takes the word where that buffer would sit.

Top module: `quint_timer`

## Requirements
- R1: After reset, every register reads 0, every counter reads 0, all channels are stopped and irq_o is 0.
- R2: Word addresses are: prescalers 0x00 (bits [7:0] for channels 0-1, bits [15:8] for channels 2-4), divider selects 0x04 (channel n at bits [4n+3:4n]), control 0x08, interrupt 0x44. Channel n has its count buffer at 0x0C+12n. Channels 0-3 have a compare buffer at 0x10+12n and an observation register at 0x14+12n. Channel 4's observation register is at 0x40. Buffers and select fields read back what was written.
- R3: A channel ticks once every (p+1)*2^(s+DIV_BASE) clock cycles, where p is its group's prescaler field and s is its divider select.
- R4: While a channel's manual-update bit is 1, its counter loads the count buffer on every clock and does not count. While that bit is 0, writes to the buffer do not change the counter.
- R5: A started channel decrements by 1 per tick. A tick that finds the counter at 0 expires the channel and sets its status bit, so a count of 0 expires on the first tick.
- R6: On expiry with auto-reload set, the counter reloads from the buffer and the channel keeps running. With auto-reload clear, the counter stays at 0 and hardware clears the channel's start bit.
- R7: Clearing start freezes the counter. Setting start again resumes from the frozen value.
- R8: Control groups start at bit 0 for channel 0 and at bit 4(k+1) for channel k≥1. Within a group, +0 is start, +1 is manual update and +2 is invert. Auto-reload is +3, except for channel 4, where it is +2 (bit 22). Bits [7:4] and bit 23 ignore writes and read 0.
- R9: At 0x44, bits [4:0] are interrupt enables and bits [9:5] are status bits. Writing 1 to a status bit clears it, writing 0 leaves it unchanged, and an expiry in the same cycle wins over the clear.
- R10: irq_o[n] is high exactly when status bit n and enable bit n are both 1.
- R11: Writes to observation addresses are ignored, and the observation register returns the live counter.
- R12: Buffers hold CNT_W bits. Writing all ones reads back 2^CNT_W-1, with the upper bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 8 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_o | output | 5 | One interrupt line per channel |

## Verification
The bench builds the block with a 16-bit counter and DIV_BASE set to 0. With this setting a divider select of 0 means divide-by-1, so with both prescalers at 0 every channel ticks on every clock. This lets each decrement, expiry and reload be checked in an exact cycle. The 16-bit width lets an all-ones write show that the upper buffer bits are dropped. Tick spacing is then measured between counter changes, so the prescaler groups and the divider ratios are checked without depending on the phase of the free-running stages.

// File: rtl/qt_pkg.sv
package qt_pkg;

    localparam int NCH    = 5;
    localparam int PRE_W  = 8;
    localparam int SEL_W  = 4;
    localparam int CTRL_W = 24;

    localparam logic [7:0] A_PRE  = 8'h00;
    localparam logic [7:0] A_SEL  = 8'h04;
    localparam logic [7:0] A_CTRL = 8'h08;
    localparam logic [7:0] A_INT  = 8'h44;

    // control group base: a one-group gap follows channel 0
    function automatic int grp_base(input int k);
        return (k == 0) ? 0 : 4 * (k + 1);
    endfunction

    function automatic int bit_start(input int k);
        return grp_base(k);
    endfunction

    function automatic int bit_manual(input int k);
        return grp_base(k) + 1;
    endfunction

    function automatic int bit_reload(input int k);
        return (k == NCH - 1) ? grp_base(k) + 2 : grp_base(k) + 3;
    endfunction

    function automatic logic [CTRL_W-1:0] ctrl_mask();
        logic [CTRL_W-1:0] m;
        m = '0;
        for (int k = 0; k < NCH; k++) begin
            m[bit_start(k)]  = 1'b1;
            m[bit_manual(k)] = 1'b1;
            m[bit_reload(k)] = 1'b1;
            if (k < NCH - 1) m[grp_base(k) + 2] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [7:0] cntb_addr(input int n);
        return 8'(12 + 12 * n);
    endfunction

    function automatic logic [7:0] cmpb_addr(input int n);
        return 8'(16 + 12 * n);
    endfunction

    function automatic logic [7:0] obs_addr(input int n);
        return (n == NCH - 1) ? 8'h40 : 8'(20 + 12 * n);
    endfunction

endpackage

// File: rtl/qt_prescale.sv
module qt_prescale #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] ratio_i,
    output logic          tick_o
);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = (st_q.cnt >= ratio_i);
        st_d.cnt = tick_o ? '0 : st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: between ticks the phase counter advances by one
    a_r3_pre_advance: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_o |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

    // R3: a tick restarts the phase
    a_r3_pre_restart: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (st_q.cnt == '0));

endmodule

// File: rtl/qt_chan.sv
module qt_chan #(
    parameter int CW       = 16,
    parameter int DIV_BASE = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pre_tick_i,
    input  logic [qt_pkg::SEL_W-1:0] sel_i,
    input  logic                     run_i,
    input  logic                     load_i,
    input  logic                     reload_i,
    input  logic [CW-1:0]            buf_i,
    output logic [CW-1:0]            cnt_o,
    output logic                     expire_o
);

    localparam int DW = (1 << qt_pkg::SEL_W) - 1 + DIV_BASE;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [DW-1:0] div;
    } ch_st_t;

    ch_st_t        st_d, st_q;
    logic [4:0]    expo;
    logic [DW:0]   one_sh;
    logic [DW-1:0] div_mask;
    logic          ch_tick;

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        expo     = 5'(sel_i) + 5'(DIV_BASE);
        one_sh   = (DW + 1)'(1) << expo;
        div_mask = one_sh[DW-1:0] - 1'b1;
        ch_tick  = pre_tick_i && ((st_q.div & div_mask) == div_mask);

        if (pre_tick_i) st_d.div = st_q.div + 1'b1;

        if (load_i) begin
            st_d.cnt = buf_i;
        end else if (run_i && ch_tick) begin
            if (st_q.cnt == '0) begin
                expire_o = 1'b1;
                if (reload_i) st_d.cnt = buf_i;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    // R4: manual update copies the buffer
    a_r4_manual_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (st_q.cnt == $past(buf_i)));

    // R7: a stopped channel holds its value
    a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !run_i) |=> $stable(st_q.cnt));

    // R5: a running nonzero counter moves by at most one
    a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && run_i && st_q.cnt != '0) |=>
        (st_q.cnt == $past(st_q.cnt) || st_q.cnt == $past(st_q.cnt) - 1'b1));

    // R5: expiry only from zero while running
    a_r5_expire_zero: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |-> (st_q.cnt == '0 && run_i && !load_i));

    // R6: auto-reload refills from the buffer
    a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && reload_i) |=> (st_q.cnt == $past(buf_i)));

endmodule

// File: rtl/quint_timer.sv
module quint_timer #(
    parameter int CNT_W    = 16,
    parameter int DIV_BASE = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic [4:0]  irq_o
);
    import qt_pkg::*;

    localparam int NGRP = 2;
    localparam int PREF_W = NGRP * PRE_W;
    localparam int SELF_W = NCH * SEL_W;
    localparam logic [CTRL_W-1:0] CMASK = ctrl_mask();

    typedef struct packed {
        logic [PREF_W-1:0]              pre;
        logic [SELF_W-1:0]              sel;
        logic [CTRL_W-1:0]              ctrl;
        logic [NCH-1:0]                 ien;
        logic [NCH-1:0]                 ist;
        logic [NCH-1:0][CNT_W-1:0]      cntb;
        logic [NCH-2:0][CNT_W-1:0]      cmpb;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [NGRP-1:0]            pre_tick;
    logic [NCH-1:0][CNT_W-1:0]  cnt;
    logic [NCH-1:0]             expire;
    logic                       unused_wdata;

    assign unused_wdata = ^bus_wdata[31:CTRL_W];

    generate
        for (genvar g = 0; g < NGRP; g++) begin : g_pre
            qt_prescale #(.PW(PRE_W)) u_pre (
                .clk     (clk),
                .rst_n   (rst_n),
                .ratio_i (regs_q.pre[g*PRE_W +: PRE_W]),
                .tick_o  (pre_tick[g])
            );
        end

        for (genvar k = 0; k < NCH; k++) begin : g_ch
            localparam int BS = bit_start(k);
            localparam int BM = bit_manual(k);
            localparam int BR = bit_reload(k);
            localparam int PG = (k < 2) ? 0 : 1;

            qt_chan #(.CW(CNT_W), .DIV_BASE(DIV_BASE)) u_ch (
                .clk        (clk),
                .rst_n      (rst_n),
                .pre_tick_i (pre_tick[PG]),
                .sel_i      (regs_q.sel[k*SEL_W +: SEL_W]),
                .run_i      (regs_q.ctrl[BS]),
                .load_i     (regs_q.ctrl[BM]),
                .reload_i   (regs_q.ctrl[BR]),
                .buf_i      (regs_q.cntb[k]),
                .cnt_o      (cnt[k]),
                .expire_o   (expire[k])
            );

            // R9: writing one clears status unless an expiry coincides
            a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_we && bus_addr == A_INT && bus_wdata[NCH+k] && !expire[k])
                |=> !regs_q.ist[k]);

            // R9: status is sticky without a clearing write
            a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                (regs_q.ist[k] && !(bus_we && bus_addr == A_INT && bus_wdata[NCH+k]))
                |=> regs_q.ist[k]);

            // R6: one-shot expiry stops the channel
            a_r6_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
                (expire[k] && !regs_q.ctrl[BR]) |=> !regs_q.ctrl[BS]);

            // R5: expiry always leaves status set
            a_r5_status_set: assert property (@(posedge clk) disable iff (!rst_n)
                expire[k] |=> regs_q.ist[k]);
        end
    endgenerate

    always_comb begin
        regs_d = regs_q;
        if (bus_we) begin
            if (bus_addr == A_PRE)  regs_d.pre  = bus_wdata[PREF_W-1:0];
            if (bus_addr == A_SEL)  regs_d.sel  = bus_wdata[SELF_W-1:0];
            if (bus_addr == A_CTRL) regs_d.ctrl = bus_wdata[CTRL_W-1:0] & CMASK;
            if (bus_addr == A_INT) begin
                regs_d.ien = bus_wdata[NCH-1:0];
                regs_d.ist = regs_q.ist & ~bus_wdata[2*NCH-1:NCH];
            end
            for (int n = 0; n < NCH; n++) begin
                if (bus_addr == cntb_addr(n)) regs_d.cntb[n] = bus_wdata[CNT_W-1:0];
            end
            for (int n = 0; n < NCH - 1; n++) begin
                if (bus_addr == cmpb_addr(n)) regs_d.cmpb[n] = bus_wdata[CNT_W-1:0];
            end
        end
        for (int k = 0; k < NCH; k++) begin
            if (expire[k]) begin
                regs_d.ist[k] = 1'b1;
                if (!regs_q.ctrl[bit_reload(k)]) regs_d.ctrl[bit_start(k)] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_PRE)  bus_rdata = 32'(regs_q.pre);
        if (bus_addr == A_SEL)  bus_rdata = 32'(regs_q.sel);
        if (bus_addr == A_CTRL) bus_rdata = 32'(regs_q.ctrl);
        if (bus_addr == A_INT)  bus_rdata = 32'({regs_q.ist, regs_q.ien});
        for (int n = 0; n < NCH; n++) begin
            if (bus_addr == cntb_addr(n)) bus_rdata = 32'(regs_q.cntb[n]);
            if (bus_addr == obs_addr(n))  bus_rdata = 32'(cnt[n]);
        end
        for (int n = 0; n < NCH - 1; n++) begin
            if (bus_addr == cmpb_addr(n)) bus_rdata = 32'(regs_q.cmpb[n]);
        end
    end

    assign irq_o = regs_q.ist & regs_q.ien;

endmodule

// File: tb/quint_timer_tb.sv
module quint_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  irq;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    quint_timer #(.CNT_W(16), .DIV_BASE(0)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rchk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic spacing(input logic [7:0] a, output int sp);
        logic [31:0] prev, cur;
        int t1, t2;
        t1 = -1; t2 = -1;
        rd(a, prev);
        for (int i = 0; i < 40; i++) begin
            cyc(1);
            rd(a, cur);
            if (cur != prev) begin
                if (t1 < 0) t1 = i;
                else if (t2 < 0) t2 = i;
            end
            prev = cur;
        end
        sp = t2 - t1;
    endtask

    task automatic t_reset();
        rchk("R1 prescale", 8'h00, 0);
        rchk("R1 select", 8'h04, 0);
        rchk("R1 control", 8'h08, 0);
        rchk("R1 interrupt", 8'h44, 0);
        rchk("R1 obs ch0", 8'h14, 0);
        rchk("R1 obs ch4", 8'h40, 0);
        rchk("R1 count buffer", 8'h0C, 0);
        chk("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_map();
        wr(8'h10, 32'h1234);
        rchk("R2 compare ch0", 8'h10, 32'h1234);
        wr(8'h34, 32'hABCD);
        rchk("R2 compare ch3", 8'h34, 32'hABCD);
        wr(8'h3C, 32'h0055);
        rchk("R2 count ch4", 8'h3C, 32'h0055);
        wr(8'h00, 32'hFFFFFFFF);
        rchk("R2 prescale fields", 8'h00, 32'hFFFF);
        wr(8'h04, 32'hFFFFFFFF);
        rchk("R2 select fields", 8'h04, 32'hFFFFF);
        wr(8'h00, 0);
        wr(8'h04, 0);
        wr(8'h0C, 32'hFFFFFFFF);
        rchk("R12 buffer width", 8'h0C, 32'hFFFF);
        wr(8'h08, 32'hFFFFFFFF);
        rchk("R8 control mask", 8'h08, 32'h7FFF0F);
        wr(8'h08, 0);
    endtask

    task automatic t_oneshot();
        wr(8'h44, 32'h1F);
        wr(8'h18, 5);
        wr(8'h08, 32'h200);
        wr(8'h08, 32'h100);
        cyc(2);
        rchk("R5 decrement", 8'h20, 3);
        cyc(3);
        rchk("R5 at zero", 8'h20, 0);
        rchk("R5 not yet expired", 8'h44, 32'h1F);
        cyc(1);
        rchk("R5 expiry status", 8'h44, 32'h5F);
        chk("R10 irq on", 32'(irq), 32'h02);
        rchk("R6 start cleared", 8'h08, 0);
        cyc(3);
        rchk("R6 one-shot holds zero", 8'h20, 0);
        rchk("R9 status sticky", 8'h44, 32'h5F);
    endtask

    task automatic t_status();
        wr(8'h44, 32'h1F);
        rchk("R9 write zero keeps", 8'h44, 32'h5F);
        wr(8'h44, 32'h5F);
        rchk("R9 write one clears", 8'h44, 32'h1F);
        chk("R10 irq off", 32'(irq), 0);
        wr(8'h44, 0);
        wr(8'h24, 0);
        wr(8'h08, 32'h2000);
        wr(8'h08, 32'h1000);
        cyc(1);
        rchk("R5 zero count first tick", 8'h44, 32'h80);
        chk("R10 masked", 32'(irq), 0);
        wr(8'h44, 32'h04);
        chk("R10 enabled", 32'(irq), 32'h04);
        wr(8'h44, 32'h80);
        rchk("R9 clear all", 8'h44, 0);
    endtask

    task automatic t_ch4();
        wr(8'h44, 32'h10);
        wr(8'h3C, 2);
        wr(8'h08, 32'h200000);
        wr(8'h08, 32'h500000);
        cyc(2);
        rchk("R6 ch4 at zero", 8'h40, 0);
        rchk("R6 ch4 no status yet", 8'h44, 32'h10);
        cyc(1);
        rchk("R6 ch4 expired", 8'h44, 32'h210);
        rchk("R8 ch4 reload bit22", 8'h40, 2);
        rchk("R6 ch4 still running", 8'h08, 32'h500000);
        chk("R10 ch4 irq", 32'(irq), 32'h10);
        wr(8'h44, 32'h210);
        rchk("R9 ch4 cleared", 8'h44, 32'h10);
        cyc(1);
        rchk("R6 ch4 periodic again", 8'h44, 32'h210);
        wr(8'h08, 0);
        wr(8'h44, 32'h210);
        wr(8'h08, 32'h200000);
        wr(8'h08, 32'h900000);
        rchk("R8 bit23 dropped", 8'h08, 32'h100000);
        cyc(3);
        rchk("R8 bit23 not reload", 8'h08, 0);
        cyc(3);
        rchk("R8 ch4 one-shot", 8'h40, 0);
        wr(8'h44, 32'h200);
    endtask

    task automatic t_freeze();
        wr(8'h0C, 10);
        wr(8'h08, 32'h2);
        wr(8'h08, 32'h1);
        cyc(3);
        rchk("R5 ch0 running", 8'h14, 7);
        wr(8'h08, 0);
        rchk("R7 frozen", 8'h14, 5);
        wr(8'h14, 32'h77);
        rchk("R11 obs write ignored", 8'h14, 5);
        cyc(4);
        rchk("R7 still frozen", 8'h14, 5);
        wr(8'h08, 32'h1);
        cyc(2);
        rchk("R7 resumed", 8'h14, 3);
        wr(8'h08, 32'h00F0);
        rchk("R8 gap ignored", 8'h08, 0);
        cyc(2);
        rchk("R8 gap stops ch0", 8'h14, 1);
    endtask

    task automatic t_manual();
        wr(8'h0C, 20);
        wr(8'h08, 32'h3);
        cyc(3);
        rchk("R4 manual holds", 8'h14, 20);
        wr(8'h0C, 30);
        cyc(1);
        rchk("R4 manual follows buffer", 8'h14, 30);
        wr(8'h08, 0);
        wr(8'h0C, 40);
        rchk("R4 buffer isolated", 8'h14, 30);
    endtask

    task automatic t_rate();
        int sp;
        wr(8'h0C, 1000);
        wr(8'h24, 1000);
        wr(8'h00, 32'h0002);
        wr(8'h08, 32'h2002);
        wr(8'h08, 32'h1001);
        spacing(8'h14, sp);
        chk("R3 ch0 prescale 2", 32'(sp), 3);
        spacing(8'h2C, sp);
        chk("R3 ch2 other group", 32'(sp), 1);
        wr(8'h00, 32'h0200);
        spacing(8'h14, sp);
        chk("R3 ch0 group0 zero", 32'(sp), 1);
        spacing(8'h2C, sp);
        chk("R3 ch2 prescale 2", 32'(sp), 3);
        wr(8'h00, 0);
        wr(8'h04, 32'h2);
        spacing(8'h14, sp);
        chk("R3 ch0 divide 4", 32'(sp), 4);
        spacing(8'h2C, sp);
        chk("R3 ch2 undivided", 32'(sp), 1);
        wr(8'h08, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_map();
        t_oneshot();
        t_status();
        t_ch4();
        t_freeze();
        t_manual();
        t_rate();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule